// File: doc/BRIEF.md
# CPU Bus DMA Arbiter for Sprite Copies and Audio Sample Fetches

This block sits between a CPU and its system bus and borrows the bus for two kinds of direct memory access. A CPU write of a page number V to a trigger address starts a copy of 256 bytes from source address V×256 into the sprite-memory data port. An audio unit may ask for a single sample byte from an address of its choice. Either request raises a halt. The halt takes effect on the next cycle in which the CPU reads. The block then owns the bus cycle by cycle until all pending work is done.

While it owns the bus, the block classifies each CPU cycle by the parity input. On even ("get") cycles it reads. On odd ("put") cycles it writes. A halt cycle always comes first and re-reads the address the CPU was about to read. Sample fetches take precedence over sprite reads once their own alignment cycles have passed. Filler cycles repeat the CPU's pending read, except when that address is a controller port, where the repeat would lose input bits. When no work remains, the halt drops and the CPU's held read goes through in that same cycle.

Top module: `dma_bus_arb`

## Requirements
- R1: During and right after reset, cpu_halt_o, bus_wr_o, smp_valid_o and spr_done_o are low, and bus_rd_o follows cpu_rd_i.
- R2: A CPU write of value V to address 0x4014 produces no bus write, and it starts a sprite copy whose source bytes are read from V×256 + k for k = 0..255. A write to any other address passes straight to the bus.
- R3: Pending work stalls only a CPU read cycle, never a CPU write cycle. The first stalled cycle reads the address the CPU is presenting.
- R4: A lone sample request stalls the CPU for 3 cycles when the halt cycle is even and for 4 cycles when it is odd. The sample byte is read at the requested address on an even cycle.
- R5: Sprite source reads occur only on even cycles, in ascending offset order. Each is followed on the next odd cycle by a write of that same byte to address 0x2004. There are 256 reads and 256 writes in total.
- R6: A lone sprite copy stalls the CPU for 514 cycles if the halt cycle is even and for 513 cycles if it is odd.
- R7: Filler cycles after the halt cycle read the halted CPU address. They issue no read at all when that address is 0x4016 or 0x4017.
- R8: A sample request arriving during a sprite copy is served on a later even cycle in place of one sprite read. The sprite offset is not disturbed, and the copy takes 2 extra cycles.
- R9: smp_valid_o pulses for one cycle after the sample read, carrying the byte read. spr_done_o pulses exactly once, one cycle after the final sprite write.
- R10: The halt drops in the cycle after the last DMA cycle. In that cycle the CPU's held read reaches the bus at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_rd_i | input | 1 | CPU read cycle request |
| cpu_wr_i | input | 1 | CPU write cycle request |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_halt_o | output | 1 | CPU stalled this cycle; hold the read |
| odd_cycle_i | input | 1 | CPU cycle parity, 1 = odd (put) |
| smp_req_i | input | 1 | Audio sample fetch request pulse |
| smp_addr_i | input | 16 | Audio sample address, taken with the request |
| smp_data_o | output | 8 | Fetched sample byte |
| smp_valid_o | output | 1 | Sample byte valid strobe |
| spr_done_o | output | 1 | Sprite copy complete strobe |
| bus_addr_o | output | 16 | System bus address |
| bus_wdata_o | output | 8 | System bus write data |
| bus_rdata_i | input | 8 | System bus read data |
| bus_rd_o | output | 1 | System bus read strobe |
| bus_wr_o | output | 1 | System bus write strobe |

## Verification
The two functions that collide are a sprite copy in progress and a sample fetch that arrives partway through it. Both want the same even cycle. The bench raises the sample request on a chosen stalled cycle, at both start parities. It then checks four things: exactly one read lands at the sample address on an even cycle, the sprite reads still step through every offset without a gap or a repeat, every byte written matches the byte read before it, and the stall grows by exactly two cycles.

// File: rtl/dma_bus_arb_pkg.sv
package dma_bus_arb_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HALT,
    ACT_DUMMY,
    ACT_SMP,
    ACT_SPR_RD,
    ACT_SPR_WR
  } dma_act_e;
endpackage

// File: rtl/dma_slot_sel.sv
module dma_slot_sel
  import dma_bus_arb_pkg::*;
(
  input  logic     own_bus_i,
  input  logic     busy_i,
  input  logic     get_i,
  input  logic     halt_i,
  input  logic     dummy_i,
  input  logic     pend_i,
  input  logic     spr_act_i,
  input  logic     cnt_odd_i,
  output dma_act_e act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (own_bus_i) begin
      if (!busy_i) act_o = ACT_HALT;
      else if (get_i) begin
        if (pend_i && !halt_i && !dummy_i) act_o = ACT_SMP;
        else if (spr_act_i)                act_o = ACT_SPR_RD;
        else                               act_o = ACT_DUMMY;
      end else begin
        if (spr_act_i && cnt_odd_i) act_o = ACT_SPR_WR;
        else                        act_o = ACT_DUMMY;
      end
    end
  end
endmodule

// File: rtl/dma_req_flags.sv
module dma_req_flags
  import dma_bus_arb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          smp_req_i,
  input  logic [AW-1:0] smp_addr_i,
  input  logic          own_bus_i,
  input  dma_act_e      act_i,
  input  logic          spr_more_i,
  output logic          halt_o,
  output logic          dummy_o,
  output logic          pend_o,
  output logic          busy_o,
  output logic [AW-1:0] smp_addr_o
);
  logic halt_q, dummy_q, pend_q, busy_q;
  logic halt_d, dummy_d, pend_d, busy_d;
  logic [AW-1:0] smp_addr_q;

  always_comb begin
    halt_d = halt_q;
    if (own_bus_i && halt_q) halt_d = 1'b0;
    if (trig_i || smp_req_i) halt_d = 1'b1;
    // a loop cycle clears halt first, dummy on the following one
    dummy_d = dummy_q;
    if (busy_q && !halt_q) dummy_d = 1'b0;
    if (smp_req_i) dummy_d = 1'b1;
    pend_d = pend_q;
    if (act_i == ACT_SMP) pend_d = 1'b0;
    if (smp_req_i) pend_d = 1'b1;
    busy_d = own_bus_i && (pend_d || spr_more_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q     <= 1'b0;
      dummy_q    <= 1'b0;
      pend_q     <= 1'b0;
      busy_q     <= 1'b0;
      smp_addr_q <= '0;
    end else begin
      halt_q  <= halt_d;
      dummy_q <= dummy_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      if (smp_req_i) smp_addr_q <= smp_addr_i;
    end
  end

  assign halt_o     = halt_q;
  assign dummy_o    = dummy_q;
  assign pend_o     = pend_q;
  assign busy_o     = busy_q;
  assign smp_addr_o = smp_addr_q;
endmodule

// File: rtl/dma_spr_ctr.sv
module dma_spr_ctr
  import dma_bus_arb_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int XFER_LEN = 256,
  localparam int OFF_W   = $clog2(XFER_LEN),
  localparam int CNT_W   = OFF_W + 1,
  localparam int PG_W    = AW - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    page_i,
  input  dma_act_e         act_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             active_o,
  output logic             more_o,
  output logic             cnt_odd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [AW-1:0]    src_addr_o,
  output logic [DW-1:0]    last_o,
  output logic             done_o
);
  logic             active_q, done_q;
  logic [PG_W-1:0]  base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    last_q;
  logic             final_wr;

  assign final_wr = (act_i == ACT_SPR_WR) && (cnt_q == CNT_W'(2 * XFER_LEN - 1));
  assign more_o   = start_i || (active_q && !final_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      done_q <= final_wr;
      if (start_i) begin
        active_q <= 1'b1;
        base_q   <= PG_W'(page_i);
        cnt_q    <= '0;
      end else if (act_i == ACT_SPR_RD) begin
        last_q <= rdata_i;
        cnt_q  <= cnt_q + 1'b1;
      end else if (act_i == ACT_SPR_WR) begin
        cnt_q <= cnt_q + 1'b1;
        if (final_wr) active_q <= 1'b0;
      end
    end
  end

  assign active_o   = active_q;
  assign cnt_odd_o  = cnt_q[0];
  assign cnt_o      = cnt_q;
  assign src_addr_o = {base_q, cnt_q[OFF_W:1]};
  assign last_o     = last_q;
  assign done_o     = done_q;
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_bus_arb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          XFER_LEN  = 256,
  parameter logic [15:0] TRIG_ADDR = 16'h4014,
  parameter logic [15:0] SPR_PORT  = 16'h2004,
  parameter logic [15:0] CTRL_ADDR = 16'h4016,
  localparam int         CNT_W     = $clog2(XFER_LEN) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_rd_i,
  input  logic          cpu_wr_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_halt_o,
  input  logic          odd_cycle_i,
  input  logic          smp_req_i,
  input  logic [AW-1:0] smp_addr_i,
  output logic [DW-1:0] smp_data_o,
  output logic          smp_valid_o,
  output logic          spr_done_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o
);
  dma_act_e         act;
  logic             halt, dummy, pend, busy, own_bus, trig;
  logic             spr_act, spr_more, cnt_odd, ctrl_hit;
  logic [CNT_W-1:0] spr_cnt;
  logic [AW-1:0]    smp_addr, spr_addr, hold_q;
  logic [DW-1:0]    spr_last, smp_data_q;
  logic             smp_valid_q;

  assign own_bus  = busy || (halt && cpu_rd_i);
  assign trig     = cpu_wr_i && !own_bus && (cpu_addr_i == AW'(TRIG_ADDR));
  // controller ports lose bits on a repeated read
  assign ctrl_hit = (hold_q[AW-1:1] == CTRL_ADDR[AW-1:1]);

  dma_req_flags #(.AW(AW)) u_flags (
    .clk_i, .rst_ni, .trig_i(trig), .smp_req_i, .smp_addr_i,
    .own_bus_i(own_bus), .act_i(act), .spr_more_i(spr_more),
    .halt_o(halt), .dummy_o(dummy), .pend_o(pend), .busy_o(busy),
    .smp_addr_o(smp_addr)
  );

  dma_spr_ctr #(.AW(AW), .DW(DW), .XFER_LEN(XFER_LEN)) u_spr (
    .clk_i, .rst_ni, .start_i(trig), .page_i(cpu_wdata_i), .act_i(act),
    .rdata_i(bus_rdata_i), .active_o(spr_act), .more_o(spr_more),
    .cnt_odd_o(cnt_odd), .cnt_o(spr_cnt), .src_addr_o(spr_addr),
    .last_o(spr_last), .done_o(spr_done_o)
  );

  dma_slot_sel u_sel (
    .own_bus_i(own_bus), .busy_i(busy), .get_i(!odd_cycle_i),
    .halt_i(halt), .dummy_i(dummy), .pend_i(pend), .spr_act_i(spr_act),
    .cnt_odd_i(cnt_odd), .act_o(act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      smp_data_q  <= '0;
      smp_valid_q <= 1'b0;
    end else begin
      if (act == ACT_HALT) hold_q <= cpu_addr_i;
      smp_valid_q <= (act == ACT_SMP);
      if (act == ACT_SMP) smp_data_q <= bus_rdata_i;
    end
  end

  always_comb begin
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = cpu_wdata_i;
    bus_rd_o    = cpu_rd_i;
    bus_wr_o    = cpu_wr_i && !trig;
    unique case (act)
      ACT_HALT:   begin bus_rd_o = 1'b1; bus_wr_o = 1'b0; end
      ACT_DUMMY:  begin bus_addr_o = hold_q; bus_rd_o = !ctrl_hit; bus_wr_o = 1'b0; end
      ACT_SMP:    begin bus_addr_o = smp_addr; bus_rd_o = 1'b1; bus_wr_o = 1'b0; end
      ACT_SPR_RD: begin bus_addr_o = spr_addr; bus_rd_o = 1'b1; bus_wr_o = 1'b0; end
      ACT_SPR_WR: begin
        bus_addr_o  = AW'(SPR_PORT);
        bus_wdata_o = spr_last;
        bus_rd_o    = 1'b0;
        bus_wr_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign cpu_halt_o  = own_bus;
  assign smp_data_o  = smp_data_q;
  assign smp_valid_o = smp_valid_q;
endmodule

// File: rtl/dma_bus_arb_chk.sv
module dma_bus_arb_chk
  import dma_bus_arb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          CNT_W     = 9,
  parameter logic [15:0] TRIG_ADDR = 16'h4014,
  parameter logic [15:0] SPR_PORT  = 16'h2004
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_halt_o,
  input logic             cpu_wr_i,
  input logic [AW-1:0]    cpu_addr_i,
  input logic             odd_cycle_i,
  input logic             bus_rd_o,
  input logic             bus_wr_o,
  input logic [AW-1:0]    bus_addr_o,
  input logic             spr_done_o,
  input logic             smp_valid_o,
  input dma_act_e         act,
  input logic [CNT_W-1:0] spr_cnt
);
  // R2
  trig_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_halt_o && cpu_wr_i && cpu_addr_i == AW'(TRIG_ADDR)) |-> !bus_wr_o);
  // R3
  halt_first_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_halt_o) |-> (bus_rd_o && bus_addr_o == cpu_addr_i));
  // R4
  smp_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_SMP) |-> !odd_cycle_i);
  // R5
  spr_wr_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_halt_o && bus_wr_o) |-> (odd_cycle_i && bus_addr_o == AW'(SPR_PORT)));
  // R8
  smp_keeps_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_SMP) |=> $stable(spr_cnt));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_done_o |=> !spr_done_o);
  // R9
  smp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(cpu_halt_o));
endmodule

bind dma_bus_arb dma_bus_arb_chk #(
  .AW(AW), .CNT_W(CNT_W), .TRIG_ADDR(TRIG_ADDR), .SPR_PORT(SPR_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_halt_o(cpu_halt_o), .cpu_wr_i(cpu_wr_i),
  .cpu_addr_i(cpu_addr_i), .odd_cycle_i(odd_cycle_i), .bus_rd_o(bus_rd_o),
  .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .spr_done_o(spr_done_o),
  .smp_valid_o(smp_valid_o), .act(act), .spr_cnt(spr_cnt)
);

// File: tb/dma_bus_arb_bench.sv
`timescale 1ns/1ps
module dma_bus_arb_bench;
  localparam logic [15:0] SMP_A = 16'h0C40;
  localparam logic [15:0] CPU_A = 16'h8123;
  // {spr, page[8], halt parity, ctrl addr, inject cycle[10], expected stall[11]}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 8'h02, 1'b0, 1'b0, 10'd0,   11'd514},
    {1'b1, 8'h07, 1'b1, 1'b0, 10'd0,   11'd513},
    {1'b1, 8'h3C, 1'b0, 1'b1, 10'd0,   11'd514},
    {1'b1, 8'hFF, 1'b1, 1'b1, 10'd0,   11'd513},
    {1'b1, 8'h11, 1'b0, 1'b0, 10'd100, 11'd516},
    {1'b1, 8'h22, 1'b1, 1'b0, 10'd37,  11'd515},
    {1'b0, 8'h00, 1'b0, 1'b0, 10'd0,   11'd3},
    {1'b0, 8'h00, 1'b1, 1'b0, 10'd0,   11'd4},
    {1'b0, 8'h00, 1'b0, 1'b1, 10'd0,   11'd3},
    {1'b0, 8'h00, 1'b1, 1'b1, 10'd0,   11'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, par;
  logic cpu_rd, cpu_wr, smp_req;
  logic [15:0] cpu_addr, smp_addr, bus_addr;
  logic [7:0]  cpu_wdata, smp_data, bus_wdata, bus_rdata;
  logic cpu_halt, smp_valid, spr_done, bus_rd, bus_wr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) par <= 1'b0; else par <= ~par;

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_rdata = mem_f(bus_addr);

  dma_bus_arb u_dma_bus_arb (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_halt_o(cpu_halt),
    .odd_cycle_i(par), .smp_req_i(smp_req), .smp_addr_i(smp_addr),
    .smp_data_o(smp_data), .smp_valid_o(smp_valid), .spr_done_o(spr_done),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0; smp_req = 1'b0;
  endtask

  task automatic run_dma(input logic [31:0] v);
    logic spr, hp, ctrl;
    logic [7:0] pg;
    int inj, exp_st, stall, rd_idx, wr_idx, rd_bad, wr_bad, dm_bad, n_smp, n_sv, n_done;
    logic halt_ok, rel_ok;
    logic [7:0] sv_data;
    logic [15:0] ha;
    spr = v[31]; pg = v[30:23]; hp = v[22]; ctrl = v[21];
    inj = int'(v[20:11]); exp_st = int'(v[10:0]);
    ha = ctrl ? (hp ? 16'h4017 : 16'h4016) : CPU_A;
    stall = 0; rd_idx = 0; wr_idx = 0; rd_bad = 0; wr_bad = 0; dm_bad = 0;
    n_smp = 0; n_sv = 0; n_done = 0; halt_ok = 0; rel_ok = 0; sv_data = '0;
    @(negedge clk); idle();
    while (par != ~hp) @(negedge clk);
    if (spr) begin
      cpu_wr = 1'b1; cpu_addr = 16'h4014; cpu_wdata = pg;
    end else begin
      smp_req = 1'b1; smp_addr = SMP_A;
    end
    #1;
    if (spr) chk(!bus_wr && !cpu_halt, "R2 trigger write suppressed", int'(bus_wr), 0);
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = ha;
      smp_req = (inj != 0 && stall == inj);
      smp_addr = SMP_A;
      #1;
      if (spr_done) n_done++;
      if (smp_valid) begin n_sv++; sv_data = smp_data; end
      if (!cpu_halt) begin
        rel_ok = bus_rd && !bus_wr && bus_addr == ha;
        break;
      end
      if (stall == 0) halt_ok = bus_rd && !bus_wr && bus_addr == ha && par == hp;
      else if (bus_wr) begin
        if (bus_addr != 16'h2004 || bus_wdata != mem_f({pg, wr_idx[7:0]}) ||
            wr_idx >= rd_idx || !par) wr_bad++;
        wr_idx++;
      end else if (bus_rd && bus_addr == SMP_A) begin
        n_smp++;
        if (par) dm_bad++;
      end else if (spr && bus_rd && bus_addr != ha && bus_addr[15:8] == pg) begin
        if (bus_addr[7:0] != rd_idx[7:0] || par) rd_bad++;
        rd_idx++;
      end else if (ctrl ? bus_rd : !(bus_rd && bus_addr == ha)) dm_bad++;
      stall++;
    end
    @(negedge clk); idle(); #1;
    if (spr_done) n_done++;
    if (smp_valid) n_sv++;
    chk(halt_ok, "R3 halt cycle reads cpu address", int'(halt_ok), 1);
    chk(stall == exp_st, spr ? (inj != 0 ? "R8 stall with sample" : "R6 stall length")
                              : "R4 sample stall length", stall, exp_st);
    chk(rel_ok, "R10 release passes cpu read", int'(rel_ok), 1);
    chk(dm_bad == 0, "R7 filler reads", dm_bad, 0);
    if (spr) begin
      chk(rd_idx == 256 && rd_bad == 0, "R5 sprite reads", rd_idx - rd_bad, 256);
      chk(wr_idx == 256 && wr_bad == 0, "R5 sprite writes", wr_idx - wr_bad, 256);
      chk(n_done == 1, "R9 done strobe", n_done, 1);
    end else chk(n_done == 0, "R9 no done without copy", n_done, 0);
    if (!spr || inj != 0) begin
      chk(n_smp == 1, spr ? "R8 sample fetched once" : "R4 sample fetched once", n_smp, 1);
      chk(n_sv == 1 && sv_data == mem_f(SMP_A), "R9 sample byte", int'(sv_data),
          int'(mem_f(SMP_A)));
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st;
    logic p0;
    idle(); cpu_addr = '0; cpu_wdata = '0; smp_addr = '0;
    repeat (2) @(negedge clk);
    #1;
    chk(!cpu_halt && !bus_rd && !bus_wr && !smp_valid && !spr_done,
        "R1 outputs in reset", int'(cpu_halt), 0);
    rst_n = 1'b1;
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = CPU_A; #1;
    chk(!cpu_halt && bus_rd && bus_addr == CPU_A, "R1 idle read passes", int'(cpu_halt), 0);

    for (int i = 0; i < NV; i++) run_dma(VEC[i]);

    // plain write passes
    @(negedge clk); idle(); cpu_wr = 1'b1; cpu_addr = 16'h0310; cpu_wdata = 8'hAB; #1;
    chk(bus_wr && bus_addr == 16'h0310 && bus_wdata == 8'hAB, "R2 normal write",
        int'(bus_wr), 1);
    // pending copy must not stall a write cycle
    @(negedge clk); cpu_addr = 16'h4014; cpu_wdata = 8'h05;
    @(negedge clk); cpu_addr = 16'h0311; cpu_wdata = 8'h3C; #1;
    chk(!cpu_halt && bus_wr && bus_addr == 16'h0311, "R3 write not stalled",
        int'(cpu_halt), 0);
    @(negedge clk); cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = CPU_A; #1;
    p0 = par; st = 0;
    while (cpu_halt && st < 2000) begin
      st++;
      @(negedge clk); #1;
    end
    chk(st == (p0 ? 513 : 514), "R6 stall after deferred read", st, p0 ? 513 : 514);
    @(negedge clk); idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule